// File: doc/BRIEF.md
# Programming Command Scan Register

This block is a test data register that sits between a boundary-scan port and a flash programming engine. A debugger loads the programming-command opcode into the instruction register. The block then places a 15-bit shift path between TDI and TDO. Each data-register scan does three things:
- It samples the answer the flash engine gave to the previous command.
- It shifts that answer out while the next command shifts in.
- On Update-DR it presents the new command to the flash engine.

Every TCK cycle the scan port spends in Run-Test/Idle after that update gives one execute strobe toward the flash logic.

The block runs entirely on TCK and has a synchronous, active-high reset. A separate TAP controller decodes the TAP states; this block takes those decodes as one-cycle-wide qualifiers. When more than one qualifier is high, the order of precedence is capture, then shift, then update, then run-idle. The flash array and the TAP state machine are outside the block.

Top module: `pcmd_dr`

## Requirements
- R1: After reset, the command output is all zeros, the execute strobe is low and TDO is 0.
- R2: The register acts only while the instruction input equals the programming-command opcode (default 4'h5). With any other instruction, the capture, shift, update and run-idle qualifiers change neither TDO, the command output nor the execute strobe.
- R3: A TCK edge with the capture qualifier loads the flash result bus into the 15-bit shift register.
- R4: Shifting is LSB first. TDO always shows bit 0 of the shift register. Each shift edge moves bits one place toward bit 0 and loads TDI into bit 14. A capture followed by 15 shift edges therefore sends out the whole captured value, bit 0 first.
- R5: An update edge copies the shift register to the command output. The command output then keeps its value through later capture, shift and run-idle edges until the next update.
- R6: After an update, each TCK edge taken in Run-Test/Idle gives exactly one execute strobe, high during the cycle that follows that edge. N idle edges give N strobes.
- R7: No execute strobe appears in Run-Test/Idle after a capture that has not been followed by an update, and none appears after reset before the first update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | TCK |
| rst_i | input | 1 | Synchronous active-high reset |
| ir_i | input | 4 | Current instruction register value |
| capture_dr_i | input | 1 | TAP is in Capture-DR |
| shift_dr_i | input | 1 | TAP is in Shift-DR |
| update_dr_i | input | 1 | TAP is in Update-DR |
| run_idle_i | input | 1 | TAP is in Run-Test/Idle |
| tdi_i | input | 1 | Serial data in |
| result_i | input | 15 | Flash engine result of the last executed command |
| tdo_o | output | 1 | Serial data out (shift register bit 0) |
| cmd_o | output | 15 | Command applied to the flash engine |
| exec_o | output | 1 | Execute strobe, one per Run-Test/Idle cycle after an update |

## Verification
The bench builds the block with its default parameters: a 15-bit register, a 4-bit instruction and opcode 5. With these values every bit position of a real command word can be reached by both shifting and capture. A bench flash model answers each executed command with a scrambled form of it. This makes each scan's shifted-out word differ from the command shifted in, so a stale or misordered capture shows up. Random scans with random idle lengths, including zero, exercise the strobe count. Directed cases cover a foreign opcode, an aborted scan with no update, and the all-ones and all-zeros words.

// File: rtl/pcmd_pkg.sv
package pcmd_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_CAPTURE = 3'd1,
        OP_SHIFT   = 3'd2,
        OP_UPDATE  = 3'd3,
        OP_RUN     = 3'd4
    } scan_op_e;

    typedef struct packed {
        logic armed;
        logic pulse;
    } exec_ctl_t;

    // Precedence when several qualifiers are high: capture, shift, update, run.
    function automatic scan_op_e decode_op(
        input logic sel,
        input logic cap,
        input logic shf,
        input logic upd,
        input logic rti
    );
        scan_op_e op;
        op = OP_NONE;
        if (sel) begin
            if (cap)      op = OP_CAPTURE;
            else if (shf) op = OP_SHIFT;
            else if (upd) op = OP_UPDATE;
            else if (rti) op = OP_RUN;
        end
        return op;
    endfunction

endpackage

// File: rtl/pcmd_shift.sv
module pcmd_shift
    import pcmd_pkg::*;
#(
    parameter int W = 15
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  scan_op_e     op_i,
    input  logic         tdi_i,
    input  logic [W-1:0] result_i,
    output logic         tdo_o,
    output logic [W-1:0] image_o
);
    localparam int TOP = W - 1;

    logic [W-1:0] sreg;
    logic [W-1:0] shifted;

    genvar g;
    generate
        for (g = 0; g < TOP; g++) begin : g_bit
            assign shifted[g] = sreg[g+1];
        end
    endgenerate
    assign shifted[TOP] = tdi_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sreg <= '0;
        end else begin
            case (op_i)
                OP_CAPTURE: sreg <= result_i;
                OP_SHIFT:   sreg <= shifted;
                default:    sreg <= sreg;
            endcase
        end
    end

    assign tdo_o   = sreg[0];
    assign image_o = sreg;

    p_capture_loads_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_CAPTURE) |=> (image_o == $past(result_i)));

    p_shift_lsb_first_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_SHIFT) |=> (image_o[TOP-1:0] == $past(image_o[TOP:1])
                                && image_o[TOP] == $past(tdi_i)));

    p_idle_holds_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_NONE) |=> $stable(image_o));

endmodule

// File: rtl/pcmd_update.sv
module pcmd_update
    import pcmd_pkg::*;
#(
    parameter int W = 15
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  scan_op_e     op_i,
    input  logic [W-1:0] image_i,
    output logic [W-1:0] cmd_o,
    output logic         armed_o
);
    logic [W-1:0] cmd_q;
    logic         armed_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cmd_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            case (op_i)
                OP_UPDATE: begin
                    cmd_q   <= image_i;
                    armed_q <= 1'b1;
                end
                OP_CAPTURE: armed_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign cmd_o   = cmd_q;
    assign armed_o = armed_q;

    p_cmd_holds_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i != OP_UPDATE) |=> $stable(cmd_o));

    p_update_copies_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_UPDATE) |=> (cmd_o == $past(image_i)));

endmodule

// File: rtl/pcmd_exec.sv
module pcmd_exec
    import pcmd_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  scan_op_e op_i,
    input  logic     armed_i,
    output logic     exec_o
);
    exec_ctl_t ctl;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl.pulse <= 1'b0;
        end else begin
            ctl.pulse <= (op_i == OP_RUN) && armed_i;
        end
    end

    assign ctl.armed = armed_i;
    assign exec_o    = ctl.pulse;

    p_no_exec_unarmed_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctl.armed |=> !exec_o);

endmodule

// File: rtl/pcmd_dr.sv
module pcmd_dr
    import pcmd_pkg::*;
#(
    parameter int          DR_W   = 15,
    parameter int          IR_W   = 4,
    parameter logic [IR_W-1:0] OPCODE = 4'h5
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [IR_W-1:0] ir_i,
    input  logic            capture_dr_i,
    input  logic            shift_dr_i,
    input  logic            update_dr_i,
    input  logic            run_idle_i,
    input  logic            tdi_i,
    input  logic [DR_W-1:0] result_i,
    output logic            tdo_o,
    output logic [DR_W-1:0] cmd_o,
    output logic            exec_o
);
    logic            sel;
    scan_op_e        op;
    logic [DR_W-1:0] image;
    logic            armed;

    assign sel = (ir_i == OPCODE);
    assign op  = decode_op(sel, capture_dr_i, shift_dr_i, update_dr_i, run_idle_i);

    pcmd_shift #(.W(DR_W)) u_shift (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .op_i     (op),
        .tdi_i    (tdi_i),
        .result_i (result_i),
        .tdo_o    (tdo_o),
        .image_o  (image)
    );

    pcmd_update #(.W(DR_W)) u_update (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .op_i    (op),
        .image_i (image),
        .cmd_o   (cmd_o),
        .armed_o (armed)
    );

    pcmd_exec u_exec (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .op_i    (op),
        .armed_i (armed),
        .exec_o  (exec_o)
    );

    p_reset_state_r1: assert property (@(posedge clk_i)
        rst_i |=> (cmd_o == '0 && !exec_o && !tdo_o));

    p_exec_from_idle_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        exec_o |-> $past(run_idle_i && sel));

    p_unselected_cmd_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !sel |=> ($stable(cmd_o) && !exec_o));

endmodule

// File: tb/sim_pcmd_dr.sv
module sim_pcmd_dr;
    localparam int W = 15;

    logic         clk = 1'b0;
    logic         rst;
    logic [3:0]   ir;
    logic         cap, shf, upd, rti, tdi;
    logic [W-1:0] result;
    logic         tdo;
    logic [W-1:0] cmd;
    logic         exe;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    logic [W-1:0] last_cmd;

    always #2 clk = ~clk;

    pcmd_dr u0 (
        .clk_i(clk), .rst_i(rst), .ir_i(ir),
        .capture_dr_i(cap), .shift_dr_i(shf), .update_dr_i(upd),
        .run_idle_i(rti), .tdi_i(tdi), .result_i(result),
        .tdo_o(tdo), .cmd_o(cmd), .exec_o(exe)
    );

    function automatic logic [W-1:0] flash_resp(input logic [W-1:0] c);
        return {c[3:0], c[W-1:4]} ^ 15'h2B4D;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_ctl();
        cap = 0; shf = 0; upd = 0; rti = 0; tdi = 0;
    endtask

    // Full scan: capture, 15 shifts, optional update. Returns the word shifted out.
    task automatic scan(input logic [W-1:0] c, input bit do_upd, output logic [W-1:0] got);
        @(negedge clk); clear_ctl(); cap = 1;
        @(negedge clk); cap = 0; shf = 1;
        for (int i = 0; i < W; i++) begin
            got[i] = tdo;
            tdi = c[i];
            @(negedge clk);
        end
        shf = 0; tdi = 0;
        if (do_upd) begin
            upd = 1;
            @(negedge clk); upd = 0;
        end
    endtask

    // n idle edges; returns number of strobes seen, checks strobe is gone afterwards.
    task automatic idle(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            rti = 1;
            @(negedge clk);
            if (exe) pulses++;
        end
        rti = 0;
        @(negedge clk);
        if (exe) pulses = pulses + 1000;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] got;
        logic [W-1:0] c;
        int p;
        int n;
        void'($urandom(32'd1234));
        clear_ctl(); ir = 4'h5; result = '0; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 cmd", cmd, '0);
        check("R1 exec", {14'd0, exe}, '0);
        check("R1 tdo", {14'd0, tdo}, '0);
        // R7 no strobe before first update
        idle(4, p);
        check("R7 no update yet", p[W-1:0], '0);

        // R3/R4/R5/R6 directed: all ones then zeros
        last_cmd = '0;
        result = flash_resp(last_cmd);
        scan(15'h7FFF, 1, got);
        check("R3 R4 shifted result", got, flash_resp(15'h0000));
        check("R5 update all-ones", cmd, 15'h7FFF);
        idle(1, p);
        check("R6 one idle one strobe", p[W-1:0], 15'd1);
        last_cmd = 15'h7FFF; result = flash_resp(last_cmd);
        scan(15'h0000, 1, got);
        check("R3 R4 after all-ones", got, flash_resp(15'h7FFF));
        check("R5 update all-zeros", cmd, 15'h0000);
        idle(3, p);
        check("R6 three strobes", p[W-1:0], 15'd3);
        last_cmd = 15'h0000; result = flash_resp(last_cmd);

        // R2 foreign opcode: nothing moves
        ir = 4'h6;
        scan(15'h1234, 1, got);
        check("R2 tdo frozen", got, '0);
        check("R2 cmd unchanged", cmd, 15'h0000);
        idle(2, p);
        check("R2 no strobe", p[W-1:0], '0);
        ir = 4'h5;

        // R7 aborted scan (no update) then idle; R5 cmd held through shifting
        scan(15'h5555, 0, got);
        check("R3 capture after foreign", got, flash_resp(15'h0000));
        check("R5 cmd held without update", cmd, 15'h0000);
        idle(3, p);
        check("R7 aborted scan no strobe", p[W-1:0], '0);
        // shift register now holds 5555: R4 shows it on the next capture? capture overwrites, so re-scan
        result = flash_resp(last_cmd);

        // Random scans
        for (int k = 0; k < 40; k++) begin
            c = W'($urandom);
            n = int'($urandom % 5);
            scan(c, 1, got);
            check("R3 R4 random capture", got, flash_resp(last_cmd));
            check("R5 random update", cmd, c);
            idle(n, p);
            check("R6 random strobes", p[W-1:0], W'(n));
            check("R5 cmd held over idle", cmd, c);
            if (n > 0) begin
                last_cmd = c;
                result = flash_resp(c);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule